// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Controller

This block produces the feedback pulse of an integer-N synthesizer loop from a fast input clock. A small behavioural two-modulus prescaler divides the input clock by ten or by eleven. A main counter and a swallow counter watch the prescaler output and steer its modulus. A programmed main count M (9 bits) and swallow count A (4 bits) give a total ratio of 10·(M+1)+A input-clock cycles for each feedback pulse. The prescaler-select line is a port, so the modulus control can be watched from outside.

A bypass request removes the prescaler. The main counter then counts input-clock cycles directly and divides by M+1. A direct-mode input marks the counts as hard-wired, and in that mode the bypass request has no effect. M, A, bypass and direct mode are parallel inputs. They are captured only on the input-clock edge that closes a division cycle, and they are also captured on every edge while reset is held.

Top module: `dmd_feedback_divider`

## Requirements
- R1: With bypass inactive and A ≤ M+1, successive `fb_pulse` assertions are exactly 10·(M+1)+A input-clock cycles apart.
- R2: With bypass inactive and A > M+1, each prescaler period of the cycle runs divided by eleven, so the spacing is 11·(M+1) cycles.
- R3: `mod_sel` = 1 selects divide-by-eleven and `mod_sel` = 0 selects divide-by-ten. Each division cycle opens with `mod_sel` equal to 1 whenever A > 0 and bypass is inactive. It stays 1 for 11·min(A, M+1) input cycles, then 0 for the rest of the cycle.
- R4: With `bypass_req` = 1 and `direct_mode` = 0, the spacing is M+1 input cycles and `mod_sel` stays 0.
- R5: With `direct_mode` = 1, `bypass_req` is ignored and the ratio follows R1/R2.
- R6: `fb_pulse` is high for one input-clock cycle per division cycle: the first cycle of the next division cycle. When the ratio is 1 it stays high.
- R7: A change of M, A, `bypass_req` or `direct_mode` during a division cycle does not alter that cycle. The values present at the cycle's final edge govern the next cycle.
- R8: Reset is synchronous and active low. While it is applied, `fb_pulse` is 0 and the configuration is captured. After release, the first `fb_pulse` is seen in the N-th cycle, counting the cycle just after the last reset edge as cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock (prescaler input) |
| rst_n | input | 1 | Synchronous active-low reset |
| m_count | input | 9 | Main count M |
| a_count | input | 4 | Swallow count A |
| bypass_req | input | 1 | Request to bypass the prescaler |
| direct_mode | input | 1 | Hard-wired count mode; masks bypass |
| mod_sel | output | 1 | Prescaler select, 1 = divide by eleven |
| fb_pulse | output | 1 | Divided feedback pulse |

## Verification
The hardest situation to reach is a configuration change that lands in the middle of a division cycle, and in particular one that flips bypass or direct mode. A wrong design would apply such a change at once instead of at the cycle boundary. The stimulus holds each random configuration for a random number of cycles that is unrelated to the current ratio, so many changes fall mid-cycle. A reference model in the bench tracks which values were present at each closing edge. Directed cases add the swallow edges A = 0, A = M+1 and A > M+1, bypass with M = 0 (ratio one), bypass masked by direct mode, the largest ratio, and a second reset during operation.

// File: rtl/dmd_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the dual-modulus feedback divider.
// Assumes: nothing beyond standard SystemVerilog.
package dmd_pkg;
    // prescaler modulus selection; value 1 means the longer modulus
    typedef enum logic {
        DIV_SHORT = 1'b0,
        DIV_LONG  = 1'b1
    } dmd_mod_e;

    localparam int DMD_PRE_SHORT_DEF = 10;
endpackage

// File: rtl/dmd_cfg_hold.sv
`timescale 1ns/1ps
// Module: dmd_cfg_hold
// Holds the count configuration for the running division cycle.
// Loads from the parallel inputs while reset is applied and on the edge
// that closes a cycle. The bypass request is masked by direct mode here.
// Assumes: load is a single-cycle strobe produced by the counter stage.
module dmd_cfg_hold #(
    parameter int M_W = 9,
    parameter int A_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    input  logic           byp_in,
    input  logic           direct_in,
    output logic [M_W-1:0] m_q,
    output logic [A_W-1:0] a_q,
    output logic           byp_q
);
    // capture configuration at reset or at a cycle boundary
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            m_q   <= m_in;
            a_q   <= a_in;
            byp_q <= byp_in & ~direct_in;
        end
    end

    // R5: bypass never takes effect when direct mode was present at load
    p_bypass_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && direct_in) |=> !byp_q);

    // R7: configuration only moves on a boundary edge
    p_cfg_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({m_q, a_q, byp_q}));
endmodule

// File: rtl/dmd_prescaler.sv
`timescale 1ns/1ps
// Module: dmd_prescaler
// Behavioural two-modulus prescaler: emits one tick every PRE_SHORT or
// PRE_SHORT+1 input cycles, as picked by sel. With bypass set, every
// input cycle is a tick.
// Assumes: sel only changes on the cycle after a tick.
module dmd_prescaler
    import dmd_pkg::*;
#(
    parameter int PRE_SHORT = DMD_PRE_SHORT_DEF
) (
    input  logic     clk,
    input  logic     rst_n,
    input  dmd_mod_e sel,
    input  logic     bypass,
    output logic     tick
);
    localparam int CW = $clog2(PRE_SHORT + 1);

    logic [CW-1:0] ph_cnt;
    logic [CW-1:0] ph_last;

    // pick terminal count from the selected modulus
    always_comb begin
        ph_last = (sel == DIV_LONG) ? CW'(PRE_SHORT) : CW'(PRE_SHORT - 1);
        tick    = bypass || (ph_cnt == ph_last);
    end

    // advance the phase counter, wrapping on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || tick) begin
            ph_cnt <= '0;
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

    // R1: the phase counter never passes the longer modulus
    p_prescale_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ph_cnt <= CW'(PRE_SHORT));
endmodule

// File: rtl/dmd_counters.sv
`timescale 1ns/1ps
// Module: dmd_counters
// Main and swallow counters. The main counter counts prescaler ticks up to
// m_lim; the swallow counter keeps the long modulus selected for the first
// a_lim ticks of each cycle. cyc_end marks the last input cycle.
// Assumes: m_lim and a_lim are held constant between boundaries.
module dmd_counters
    import dmd_pkg::*;
#(
    parameter int M_W = 9,
    parameter int A_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           bypass,
    input  logic [M_W-1:0] m_lim,
    input  logic [A_W-1:0] a_lim,
    output dmd_mod_e       sel,
    output logic           cyc_end
);
    logic [M_W-1:0] main_cnt;
    logic [A_W-1:0] swal_cnt;

    // modulus select and end-of-cycle decode
    always_comb begin
        sel     = (!bypass && (swal_cnt < a_lim)) ? DIV_LONG : DIV_SHORT;
        cyc_end = tick && (main_cnt == m_lim);
    end

    // count ticks; swallow counter advances while the long modulus runs
    always_ff @(posedge clk) begin
        if (!rst_n || cyc_end) begin
            main_cnt <= '0;
            swal_cnt <= '0;
        end else if (tick) begin
            main_cnt <= main_cnt + 1'b1;
            if (sel == DIV_LONG) begin
                swal_cnt <= swal_cnt + 1'b1;
            end
        end
    end

    // R1: main counter stays within the programmed limit
    p_main_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        main_cnt <= m_lim);

    // R2: swallowed ticks never outnumber counted ticks
    p_swallow_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        M_W'(swal_cnt) <= main_cnt);

    // R3: long modulus is released only at a prescaler tick
    p_modsel_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel == DIV_LONG) |-> $past(tick));
endmodule

// File: rtl/dmd_feedback_divider.sv
`timescale 1ns/1ps
// Module: dmd_feedback_divider (top)
// Divides clk_in by 10*(M+1)+A using a modelled 10/11 prescaler plus main
// and swallow counters, or by M+1 when the prescaler is bypassed.
// fb_pulse is registered and lasts one input cycle.
// Assumes: all inputs are synchronous to clk_in.
module dmd_feedback_divider
    import dmd_pkg::*;
#(
    parameter int M_W       = 9,
    parameter int A_W       = 4,
    parameter int PRE_SHORT = DMD_PRE_SHORT_DEF
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_count,
    input  logic [A_W-1:0] a_count,
    input  logic           bypass_req,
    input  logic           direct_mode,
    output logic           mod_sel,
    output logic           fb_pulse
);
    logic [M_W-1:0] m_q;
    logic [A_W-1:0] a_q;
    logic           byp_q;
    logic           tick;
    logic           cyc_end;
    dmd_mod_e       sel;

    dmd_cfg_hold #(.M_W(M_W), .A_W(A_W)) u_cfg (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .load      (cyc_end),
        .m_in      (m_count),
        .a_in      (a_count),
        .byp_in    (bypass_req),
        .direct_in (direct_mode),
        .m_q       (m_q),
        .a_q       (a_q),
        .byp_q     (byp_q)
    );

    dmd_prescaler #(.PRE_SHORT(PRE_SHORT)) u_pre (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .sel    (sel),
        .bypass (byp_q),
        .tick   (tick)
    );

    dmd_counters #(.M_W(M_W), .A_W(A_W)) u_cnt (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .tick    (tick),
        .bypass  (byp_q),
        .m_lim   (m_q),
        .a_lim   (a_q),
        .sel     (sel),
        .cyc_end (cyc_end)
    );

    // expose the modulus select
    always_comb mod_sel = (sel == DIV_LONG);

    // register the end-of-cycle strobe as the feedback pulse
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            fb_pulse <= 1'b0;
        end else begin
            fb_pulse <= cyc_end;
        end
    end

    // R6: a pulse lasts one cycle unless the ratio is one
    p_fp_single_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
        (fb_pulse && !(byp_q && m_q == '0)) |=> !fb_pulse);

    // R4: bypass keeps the prescaler select low
    p_bypass_sel_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
        byp_q |-> !mod_sel);
endmodule

// File: tb/sim_dmd_feedback_divider.sv
`timescale 1ns/1ps
// Bench: random configurations held for random spans, plus directed edges,
// checked against a reference ratio computed from the requirements.
module sim_dmd_feedback_divider;
    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic [8:0] dm = 9'd5;
    logic [3:0] da = 4'd2;
    logic       db = 1'b0;
    logic       dd = 1'b0;
    logic       mod_sel;
    logic       fb_pulse;

    int checks = 0;
    int errors = 0;

    dmd_feedback_divider u0 (
        .clk_in      (clk_in),
        .rst_n       (rst_n),
        .m_count     (dm),
        .a_count     (da),
        .bypass_req  (db),
        .direct_mode (dd),
        .mod_sel     (mod_sel),
        .fb_pulse    (fb_pulse)
    );

    always #10 clk_in = ~clk_in;

    function automatic int min_sw(int m, int a);
        return (a < m + 1) ? a : m + 1;
    endfunction

    function automatic int exp_len(int m, int a, bit b, bit d);
        if (b && !d) return m + 1;
        return 10 * (m + 1) + min_sw(m, a);
    endfunction

    function automatic int exp_hi(int m, int a, bit b, bit d);
        if (b && !d) return 0;
        return 11 * min_sw(m, a);
    endfunction

    function automatic string req_of(int m, int a, bit b, bit d);
        if (b && !d) return "R4";
        if (b && d)  return "R5";
        if (a > m + 1) return "R2";
        return "R1";
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor state
    bit rst_prev = 1'b0;
    int s_m = 0, s_a = 0; bit s_b = 0, s_d = 0;
    int e_m = 0, e_a = 0; bit e_b = 0, e_d = 0;
    bit mid_change = 0;
    int cnt = 0;
    int hcnt = 0;

    // sample away from the active edge and compare with the reference
    always @(negedge clk_in) begin
        if (!rst_prev) begin
            chk(fb_pulse == 1'b0, "R8", int'(fb_pulse), 0);
            e_m = s_m; e_a = s_a; e_b = s_b; e_d = s_d;
            cnt = 0; hcnt = 0; mid_change = 0;
        end else begin
            cnt++;
            if (fb_pulse) begin
                chk(cnt == exp_len(e_m, e_a, e_b, e_d),
                    {req_of(e_m, e_a, e_b, e_d), mid_change ? ",R7,R6,R8" : ",R6,R8"},
                    cnt, exp_len(e_m, e_a, e_b, e_d));
                chk(hcnt == exp_hi(e_m, e_a, e_b, e_d), "R3", hcnt,
                    exp_hi(e_m, e_a, e_b, e_d));
                e_m = s_m; e_a = s_a; e_b = s_b; e_d = s_d;
                cnt = 0; hcnt = 0; mid_change = 0;
                chk(mod_sel == ((e_a > 0) && !(e_b && !e_d)), "R3",
                    int'(mod_sel), int'((e_a > 0) && !(e_b && !e_d)));
            end
            if (cnt > 6000) begin
                chk(1'b0, "R1", cnt, exp_len(e_m, e_a, e_b, e_d));
                cnt = 0;
            end
        end
        hcnt += int'(mod_sel);
        if (rst_prev && (int'(dm) != s_m || int'(da) != s_a || db != s_b || dd != s_d))
            mid_change = 1;
        rst_prev = rst_n;
        s_m = int'(dm); s_a = int'(da); s_b = db; s_d = dd;
    end

    task automatic drive(int m, int a, bit b, bit d);
        @(posedge clk_in); #2;
        dm = 9'(m); da = 4'(a); db = b; dd = d;
    endtask

    task automatic directed(int m, int a, bit b, bit d);
        drive(m, a, b, d);
        repeat (2 * exp_len(m, a, b, d) + 30) @(posedge clk_in);
    endtask

    // watchdog
    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk_in);
        #2 rst_n = 1'b1;
        repeat (200) @(posedge clk_in);
        // directed corners
        directed(0, 0, 0, 0);     // R1 ratio 10
        directed(0, 1, 0, 0);     // R1 ratio 11
        directed(3, 4, 0, 0);     // R1 A = M+1
        directed(0, 5, 0, 0);     // R2 A > M+1
        directed(2, 9, 0, 0);     // R2
        directed(0, 3, 1, 0);     // R4 ratio one, R6
        directed(7, 2, 1, 0);     // R4
        directed(2, 3, 1, 1);     // R5
        // random configurations with mid-cycle changes (R7)
        for (int i = 0; i < 220; i++) begin
            int m;
            m = ($urandom % 16 == 0) ? int'($urandom % 200) : int'($urandom % 40);
            drive(m, int'($urandom % 16), ($urandom % 3) == 0, ($urandom % 4) == 0);
            repeat (1 + $urandom % 250) @(posedge clk_in);
        end
        // second reset in operation (R8)
        drive(4, 1, 0, 0);
        #0 rst_n = 1'b0;
        repeat (3) @(posedge clk_in);
        #2 rst_n = 1'b1;
        repeat (150) @(posedge clk_in);
        // largest ratio
        directed(511, 15, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule